// File: doc/BRIEF.md
# Reference Clock Pre-Divider

This block sits behind one reference clock input and reduces its rate to something a downstream phase-locked loop can track. It runs in the reference clock domain and produces a clock-enable pulse train, not a derived clock. Two stages are cascaded. The first is an optional high-rate prescaler that either passes every cycle or emits one tick every 4 or every 5 cycles. The second is an integer divide-by-N down-counter that can be skipped.

The DivN stage is active only when at least one of two enable bits is set (`direct_i`, `lock8k_i`), and the sync-sharing flag is clear. With both enable bits clear, or with the input also acting as a frame-sync reference, the chain period is set by the prescaler alone. For 2, 4 and 8 kHz inputs the whole chain is placed in pass-through by clearing the prescaler select and both enable bits.

Whenever any control input changes, both stages restart together. This keeps a partial period from reaching the output. The overall output period is P = D × N cycles, where D is the prescaler ratio and N is the effective DivN ratio.

Top module: `ref_prediv`

## Requirements
- R1: `hf_sel_i` sets the prescaler ratio D: 2'b00 gives D=1 (pass), 2'b01 gives D=4, 2'b10 gives D=5, and 2'b11 is treated as pass (D=1).
- R2: When DivN is active, the output has one pulse per N prescaler ticks, where N is the unsigned value of `divn_i`. The output period is P = D×N clock cycles.
- R3: DivN is bypassed (N=1) when `direct_i`=0 and `lock8k_i`=0, whatever the value of `divn_i`.
- R4: `sync_share_i`=1 forces DivN into bypass (N=1), whatever the values of `direct_i`, `lock8k_i` and `divn_i`.
- R5: A `divn_i` of 0 or 1 behaves the same as DivN bypass (N=1).
- R6: A change on any control input is seen at the next rising edge E0. Both stages restart at E0, and the output register is cleared at E0. The first pulse is registered exactly P edges after E0.
- R7: While `rst_ni` is low, `div_en_o` is 0. The first rising edge after reset is treated as a restart, so the first pulse is registered P edges later.
- R8: When P>1, every output pulse lasts one cycle. When P=1 (full pass-through) and the controls are steady, `div_en_o` stays high.
- R9: In steady state, consecutive pulses are exactly P cycles apart, and any window of 4×P cycles that starts at a pulse holds exactly 4 further pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hf_sel_i | input | 2 | Prescaler select (R1 encoding) |
| direct_i | input | 1 | DivN enable bit A |
| lock8k_i | input | 1 | DivN enable bit B |
| sync_share_i | input | 1 | Input also used as frame sync; forces DivN bypass |
| divn_i | input | DIVN_W | DivN ratio N |
| div_en_o | output | 1 | Divided clock-enable pulse |

## Verification
Each prescaler setting is tried in pass-through and combined with DivN ratios from 2 up to the full-scale 255. This separates a wrong D from a wrong N through the product P. DivN is then given a large `divn_i` while each bypass condition holds in turn: both enable bits clear, and the sync-sharing flag set with DivN enabled. The output period shows whether the bypass took effect. Ratios of 0 and 1 are checked against plain bypass. Every configuration change is made in the middle of a running period, so the first-pulse delay shows whether the counters were cleared or kept a partial period.

// File: rtl/pre_div_pkg.sv
package pre_div_pkg;
  typedef enum logic [1:0] {
    HF_PASS = 2'b00,
    HF_DIV4 = 2'b01,
    HF_DIV5 = 2'b10,
    HF_RSVD = 2'b11
  } hf_sel_e;

  localparam int unsigned HF_CNT_W = 3;

  // Terminal count of the prescaler for a given select (ratio - 1)
  function automatic logic [HF_CNT_W-1:0] hf_last(input logic [1:0] sel);
    case (hf_sel_e'(sel))
      HF_DIV4: hf_last = HF_CNT_W'(3);
      HF_DIV5: hf_last = HF_CNT_W'(4);
      default: hf_last = '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_watch.sv
module cfg_watch #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cfg_i,
  output logic         restart_o
);
  logic [W-1:0] cfg_q;
  logic         pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      pend_q <= 1'b1;
    end else begin
      cfg_q  <= cfg_i;
      pend_q <= 1'b0;
    end
  end

  // first edge after reset always restarts
  assign restart_o = pend_q | (cfg_i != cfg_q);
endmodule

// File: rtl/hf_prescaler.sv
module hf_prescaler
  import pre_div_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       restart_i,
  input  logic [1:0] hf_sel_i,
  output logic       tick_o
);
  logic [HF_CNT_W-1:0] last, cnt_q;

  assign last = hf_last(hf_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (restart_i)       cnt_q <= '0;
    else if (cnt_q >= last)   cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = ~restart_i & (cnt_q == last);
endmodule

// File: rtl/divn_stage.sv
module divn_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         tick_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] cnt_o,
  output logic         pulse_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= reload_i;
    else if (tick_i)    cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = tick_i & (cnt_q == '0);
endmodule

// File: rtl/ref_prediv.sv
module ref_prediv
  import pre_div_pkg::*;
#(
  parameter int unsigned DIVN_W = 8,
  parameter bit          HAS_HF = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        hf_sel_i,
  input  logic              direct_i,
  input  logic              lock8k_i,
  input  logic              sync_share_i,
  input  logic [DIVN_W-1:0] divn_i,
  output logic              div_en_o
);
  localparam int unsigned CFG_W = 2 + 3 + DIVN_W;

  logic [CFG_W-1:0]  cfg;
  logic              restart, pre_tick, div_pulse, divn_on, div_en_q;
  logic [DIVN_W-1:0] n_last, dn_cnt;

  assign cfg     = {hf_sel_i, direct_i, lock8k_i, sync_share_i, divn_i};
  assign divn_on = (direct_i | lock8k_i) & ~sync_share_i;
  // N of 0 or 1 collapses to bypass
  assign n_last  = (divn_on && divn_i > DIVN_W'(1)) ? divn_i - DIVN_W'(1) : '0;

  cfg_watch #(.W(CFG_W)) u_watch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .restart_o (restart)
  );

  generate
    if (HAS_HF) begin : g_hf
      hf_prescaler u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .hf_sel_i  (hf_sel_i),
        .tick_o    (pre_tick)
      );
    end else begin : g_no_hf
      assign pre_tick = ~restart;
    end
  endgenerate

  divn_stage #(.W(DIVN_W)) u_divn (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .tick_i    (pre_tick),
    .reload_i  (n_last),
    .cnt_o     (dn_cnt),
    .pulse_o   (div_pulse)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_en_q <= 1'b0;
    else         div_en_q <= div_pulse;
  end

  assign div_en_o = div_en_q;
endmodule

// File: rtl/ref_prediv_chk.sv
module ref_prediv_chk #(
  parameter int unsigned DIVN_W = 8,
  parameter bit          HAS_HF = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        hf_sel_i,
  input logic              direct_i,
  input logic              lock8k_i,
  input logic              sync_share_i,
  input logic [DIVN_W-1:0] divn_i,
  input logic              div_en_o,
  input logic              pre_tick_i,
  input logic [DIVN_W-1:0] dn_cnt_i,
  input logic              restart_i
);
  logic [DIVN_W+4:0] cfg;
  logic [DIVN_W-1:0] nm1;
  logic              hf_div, n_one, bypass_all;
  logic [1:0]        arm_q;

  assign cfg        = {hf_sel_i, direct_i, lock8k_i, sync_share_i, divn_i};
  assign hf_div     = HAS_HF && (hf_sel_i == 2'b01 || hf_sel_i == 2'b10);
  assign n_one      = sync_share_i || !(direct_i || lock8k_i) || divn_i <= DIVN_W'(1);
  assign nm1        = n_one ? '0 : divn_i - DIVN_W'(1);
  assign bypass_all = !hf_div && n_one;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            arm_q <= 2'd0;
    else if (arm_q != 2'd2) arm_q <= arm_q + 2'd1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_quiet_r7: assert (!div_en_o);
  end

  p_quiet_after_change_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg) |=> !div_en_o);

  p_full_bypass_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_q == 2'd2) && $stable(cfg) && bypass_all |=> div_en_o);

  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_en_o && !bypass_all |=> !div_en_o);

  p_prescale_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_i && hf_div |=> !pre_tick_i);

  p_divn_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_i && (dn_cnt_i == '0) && !restart_i |=> dn_cnt_i == $past(nm1));
endmodule

bind ref_prediv ref_prediv_chk #(.DIVN_W(DIVN_W), .HAS_HF(HAS_HF)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hf_sel_i     (hf_sel_i),
  .direct_i     (direct_i),
  .lock8k_i     (lock8k_i),
  .sync_share_i (sync_share_i),
  .divn_i       (divn_i),
  .div_en_o     (div_en_o),
  .pre_tick_i   (pre_tick),
  .dn_cnt_i     (dn_cnt),
  .restart_i    (restart)
);

// File: tb/ref_prediv_tb.sv
module ref_prediv_tb;
  localparam int unsigned DIVN_W = 8;
  localparam int          WIN    = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic [1:0]        hf_sel_i;
  logic              direct_i, lock8k_i, sync_share_i;
  logic [DIVN_W-1:0] divn_i;
  logic              div_en_o;

  always #2.5 clk_i = ~clk_i;

  ref_prediv #(.DIVN_W(DIVN_W)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .hf_sel_i(hf_sel_i), .direct_i(direct_i),
    .lock8k_i(lock8k_i), .sync_share_i(sync_share_i), .divn_i(divn_i),
    .div_en_o(div_en_o)
  );

  typedef struct {
    int    period;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_fail = 0, issued = 0, done_n = 0;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: pops an expectation at the restart edge and scores the pulse train
  initial begin
    exp_t cur;
    bit   active = 1'b0, first = 1'b0;
    int   since = 0, last = 0, wstart = 0, cnt = 0;
    forever begin
      @(posedge clk_i); #1;
      if (!active && q.size() > 0) begin
        cur = q.pop_front();
        active = 1'b1; first = 1'b0; since = 0; cnt = 0;
        chk(!div_en_o, {cur.tag, " R6"}, "output at restart edge", int'(div_en_o), 0);
      end else if (active) begin
        since++;
        if (div_en_o) begin
          if (!first) begin
            chk(since == cur.period, {cur.tag, " R6"}, "first pulse delay", since, cur.period);
            first = 1'b1; last = since; wstart = since; cnt = 0;
          end else begin
            chk(since - last == cur.period, {cur.tag, " R9"}, "pulse gap", since - last, cur.period);
            last = since; cnt++;
          end
        end else if (!first && since > cur.period) begin
          chk(1'b0, {cur.tag, " R6"}, "first pulse missing by cycle", since, cur.period);
          active = 1'b0; done_n++;
        end
        if (active && first && since == wstart + WIN * cur.period) begin
          chk(cnt == WIN, {cur.tag, " R9"}, "pulses in window", cnt, WIN);
          active = 1'b0; done_n++;
        end
      end
    end
  end

  // driver: applies a configuration mid-stream and queues the expected period
  task automatic apply(input logic [1:0] sel, input logic dir, input logic lk,
                       input logic sy, input int n, input int period, input string tag);
    exp_t e;
    @(negedge clk_i);
    hf_sel_i = sel; direct_i = dir; lock8k_i = lk; sync_share_i = sy;
    divn_i = DIVN_W'(n);
    e.period = period; e.tag = tag;
    q.push_back(e);
    issued++;
    wait (done_n == issued);
  endtask

  initial begin
    exp_t e;
    rst_ni = 1'b0;
    hf_sel_i = 2'b00; direct_i = 1'b0; lock8k_i = 1'b0; sync_share_i = 1'b0;
    divn_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!div_en_o, "R7", "output in reset", int'(div_en_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    e.period = 1; e.tag = "R7 R8";
    q.push_back(e);
    issued++;
    wait (done_n == issued);

    apply(2'b01, 1'b0, 1'b0, 1'b0,   9,    4, "R1 R3 div4 divn off");
    apply(2'b10, 1'b0, 1'b0, 1'b0,   9,    5, "R1 R3 div5 divn off");
    apply(2'b11, 1'b0, 1'b0, 1'b0,   0,    1, "R1 reserved select");
    apply(2'b00, 1'b1, 1'b0, 1'b0,   6,    6, "R2 direct N6");
    apply(2'b00, 1'b0, 1'b1, 1'b0,   3,    3, "R2 lock8k N3");
    apply(2'b01, 1'b1, 1'b0, 1'b0,   3,   12, "R2 div4 N3");
    apply(2'b10, 1'b0, 1'b1, 1'b0,   7,   35, "R2 div5 N7");
    apply(2'b10, 1'b1, 1'b1, 1'b0, 255, 1275, "R2 div5 N255");
    apply(2'b01, 1'b1, 1'b0, 1'b1,   7,    4, "R4 sync share");
    apply(2'b00, 1'b1, 1'b0, 1'b0,   1,    1, "R5 N1");
    apply(2'b10, 1'b1, 1'b0, 1'b0,   0,    5, "R5 N0");
    apply(2'b00, 1'b1, 1'b0, 1'b0,   2,    2, "R8 N2");
    apply(2'b01, 1'b1, 1'b0, 1'b0,   5,   20, "R6 ratio change");
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(1'b0, "R9", "watchdog expired, checks done", done_n, issued);
    summary();
  end
endmodule